// File: doc/BRIEF.md
# Parallel Port Control Register Core

This block is the register and addressing core of a programmable parallel I/O device with three 8-bit ports (A, B and C) and an 8-bit CPU bus. Port C is managed as two independent nibbles, an upper one that belongs to group A and a lower one that belongs to group B. The block decodes an active-low chip select, active-low read and write strobes and a two-bit register address. It keeps a configuration register that sets the direction of each port segment and the operating mode of each group.

A write to the configuration address carries one of two command kinds, chosen by bit 7 of the data. A full configuration word replaces the mode and direction settings and clears every output latch. A single-bit command sets or clears one port C latch bit and leaves the configuration unchanged. In simple I/O mode, output segments drive their latched values onto the pins, and input segments are read live from the pins with no latch.

The strobed and bidirectional handshake modes are implemented elsewhere. This block only exports the decoded group modes to those blocks. The CPU side is a plain register bus rather than a stream, so it has no valid/ready pair and no back-pressure. A write completes on the clock edge at which it is sampled, and a read returns its value combinationally during the strobe. Pad tri-state control is exported as per-pin output enables and a bus output enable.

Top module: `pio_ctrl_core`

## Requirements
- R1: While `rst` is high and on the cycle after it, all port output enables are 0, all output latches are 0, `bus_oe` is 0, and the configuration is every segment input with group modes 0.
- R2: Address 0 selects port A, 1 selects port B, 2 selects port C and 3 selects the configuration register. A write takes effect at the rising clock edge where `cs_n`=0 and `wr_n`=0, and is visible in the next cycle. With `cs_n`=1 nothing changes.
- R3: A configuration write with bit 7 = 1 sets the following fields. Bit 0 sets the port C lower direction, bit 1 sets the port B direction, bit 2 sets the group B mode and bit 3 sets the port C upper direction. Bit 4 sets the port A direction, and bits 6..5 set the group A mode. A direction bit of 1 means input. The group A mode code is exported as 00 for mode 0, 01 for mode 1, and 10 for either 10 or 11.
- R4: A configuration write with bit 7 = 1 clears all port A, B and C output latches to 0.
- R5: A configuration write with bit 7 = 0 writes bit 0 into port C latch bit n, where n is the value of bits 3..1. Bits 6..4 are ignored, and no other latch bit changes (e.g. 0Fh sets bit 7, 0Eh clears bit 7, 07h sets bit 3).
- R6: A bit 7 = 0 configuration write leaves the modes and the direction settings unchanged.
- R7: An output segment drives its pins with output enable 1 and its latched value, and a read of it returns the latch. An input segment has output enable 0, and a read of it returns the live pin value.
- R8: A read of port C combines the two nibbles independently: each nibble returns the latch if it is an output and the pins if it is an input. Configuration words 83h and 91h give the direction patterns that R3 implies.
- R9: `bus_oe` is 1 only while `cs_n`=0 and `rd_n`=0. A read of address 3 returns 0, and `bus_out` is 0 whenever the bus is not driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Active-high synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Register address |
| bus_in | input | 8 | CPU write data |
| bus_out | output | 8 | CPU read data |
| bus_oe | output | 1 | CPU data bus drive enable |
| pa_in | input | 8 | Port A pin inputs |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 8 | Port A per-pin output enable |
| pb_in | input | 8 | Port B pin inputs |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 8 | Port B per-pin output enable |
| pc_in | input | 8 | Port C pin inputs |
| pc_out | output | 8 | Port C output latch |
| pc_oe | output | 8 | Port C per-pin output enable |
| grp_a_mode | output | 2 | Group A mode code for the handshake blocks |
| grp_b_mode | output | 1 | Group B mode for the handshake blocks |

## Verification
A corrupted configuration register appears at once on the pin enables and the exported modes, in the cycle after the write that caused it. A bad latch appears on the `*_out` pins and in readback of any output segment at the next access. A bit command that reaches the wrong bit, or that disturbs the configuration, is caught by comparing every port C pin and mode output after each command against a bench model. A wrong read multiplex shows on `bus_out` during the same read strobe. All 16 direction combinations are swept against every mode code.

// File: rtl/pio_pkg.sv
package pio_pkg;

  typedef enum logic [1:0] {
    SEL_A   = 2'b00,
    SEL_B   = 2'b01,
    SEL_C   = 2'b10,
    SEL_CFG = 2'b11
  } pio_sel_e;

  typedef struct packed {
    logic [1:0] a_mode;
    logic       a_in;
    logic       cu_in;
    logic       b_mode;
    logic       b_in;
    logic       cl_in;
  } pio_cfg_t;

  localparam pio_cfg_t CFG_RESET = '{a_mode: 2'b00, a_in: 1'b1, cu_in: 1'b1,
                                     b_mode: 1'b0, b_in: 1'b1, cl_in: 1'b1};

  function automatic pio_cfg_t unpack_cfg(input logic [7:0] w);
    pio_cfg_t c;
    c.a_mode = w[6] ? 2'b10 : {1'b0, w[5]};
    c.a_in   = w[4];
    c.cu_in  = w[3];
    c.b_mode = w[2];
    c.b_in   = w[1];
    c.cl_in  = w[0];
    return c;
  endfunction

endpackage

// File: rtl/pio_bus_decode.sv
module pio_bus_decode
  import pio_pkg::*;
(
  input  logic       cs_n,
  input  logic       rd_n,
  input  logic       wr_n,
  input  logic [1:0] addr,
  input  logic       clk,
  input  logic       rst,
  output logic       wr_a,
  output logic       wr_b,
  output logic       wr_c,
  output logic       wr_cfg,
  output logic       rd_act,
  output pio_sel_e   rd_sel
);

  logic wr_act;

  assign wr_act = !cs_n && !wr_n;
  assign rd_act = !cs_n && !rd_n;
  assign rd_sel = pio_sel_e'(addr);

  always_comb begin
    wr_a   = 1'b0;
    wr_b   = 1'b0;
    wr_c   = 1'b0;
    wr_cfg = 1'b0;
    if (wr_act) begin
      unique case (pio_sel_e'(addr))
        SEL_A:   wr_a   = 1'b1;
        SEL_B:   wr_b   = 1'b1;
        SEL_C:   wr_c   = 1'b1;
        SEL_CFG: wr_cfg = 1'b1;
        default: ;
      endcase
    end
  end

  // R2: a write strobe reaches at most one register.
  assert_one_target_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wr_a, wr_b, wr_c, wr_cfg}));

endmodule

// File: rtl/pio_cfg_reg.sv
module pio_cfg_reg
  import pio_pkg::*;
#(
  parameter int DW   = 8,
  localparam int IDXW = $clog2(DW)
)(
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_cfg,
  input  logic [7:0]      din,
  output pio_cfg_t        cfg,
  output logic            mode_load,
  output logic [DW-1:0]   bit_we,
  output logic            bit_val
);

  pio_cfg_t      cfg_q;
  logic          cmd_bit;
  logic [IDXW-1:0] bit_idx;

  assign mode_load = wr_cfg && din[7];
  assign cmd_bit   = wr_cfg && !din[7];
  assign bit_idx   = din[IDXW:1];
  assign bit_val   = din[0];

  always_comb begin
    bit_we = '0;
    if (cmd_bit) bit_we[bit_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)            cfg_q <= CFG_RESET;
    else if (mode_load) cfg_q <= unpack_cfg(din);
  end

  assign cfg = cfg_q;

  // R6: a single-bit command leaves the configuration alone.
  assert_bitcmd_keeps_cfg_R6: assert property (@(posedge clk) disable iff (rst)
    cmd_bit |=> $stable(cfg_q));

  // R3: the reserved group A code 11 never reaches the mode output.
  assert_mode_code_R3: assert property (@(posedge clk) disable iff (rst)
    cfg_q.a_mode != 2'b11);

endmodule

// File: rtl/pio_port_latch.sv
module pio_port_latch #(
  parameter int W = 8
)(
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] ldata,
  input  logic [W-1:0] bit_we,
  input  logic         bit_val,
  input  logic         dir_in,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] q,
  output logic [W-1:0] oe,
  output logic [W-1:0] rdata
);

  logic [W-1:0] q_r;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      q_r <= '0;
    end else if (load) begin
      q_r <= ldata;
    end else begin
      for (int i = 0; i < W; i++) begin
        if (bit_we[i]) q_r[i] <= bit_val;
      end
    end
  end

  assign q     = q_r;
  assign oe    = {W{!dir_in}};
  assign rdata = dir_in ? pin_in : q_r;

  // R4: a configuration word empties the latch.
  assert_clear_latch_R4: assert property (@(posedge clk) disable iff (rst)
    clr |=> q_r == '0);

  // R5: a single-bit command flips at most one latch bit.
  assert_single_bit_R5: assert property (@(posedge clk) disable iff (rst)
    (|bit_we) && !clr && !load |=> $countones(q_r ^ $past(q_r)) <= 1);

endmodule

// File: rtl/pio_ctrl_core.sv
module pio_ctrl_core
  import pio_pkg::*;
#(
  parameter int DW = 8,
  localparam int HALF = DW / 2
)(
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] bus_in,
  output logic [DW-1:0] bus_out,
  output logic          bus_oe,
  input  logic [DW-1:0] pa_in,
  output logic [DW-1:0] pa_out,
  output logic [DW-1:0] pa_oe,
  input  logic [DW-1:0] pb_in,
  output logic [DW-1:0] pb_out,
  output logic [DW-1:0] pb_oe,
  input  logic [DW-1:0] pc_in,
  output logic [DW-1:0] pc_out,
  output logic [DW-1:0] pc_oe,
  output logic [1:0]    grp_a_mode,
  output logic          grp_b_mode
);

  logic          wr_a, wr_b, wr_c, wr_cfg, rd_act;
  pio_sel_e      rd_sel;
  pio_cfg_t      cfg;
  logic          mode_load, bit_val;
  logic [DW-1:0] bit_we;
  logic [DW-1:0] ra, rb, rc;

  pio_bus_decode u_dec (
    .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
    .clk(clk), .rst(rst),
    .wr_a(wr_a), .wr_b(wr_b), .wr_c(wr_c), .wr_cfg(wr_cfg),
    .rd_act(rd_act), .rd_sel(rd_sel)
  );

  pio_cfg_reg #(.DW(DW)) u_cfg (
    .clk(clk), .rst(rst), .wr_cfg(wr_cfg), .din(bus_in[7:0]),
    .cfg(cfg), .mode_load(mode_load), .bit_we(bit_we), .bit_val(bit_val)
  );

  pio_port_latch #(.W(DW)) u_pa (
    .clk(clk), .rst(rst), .clr(mode_load), .load(wr_a), .ldata(bus_in),
    .bit_we('0), .bit_val(1'b0), .dir_in(cfg.a_in), .pin_in(pa_in),
    .q(pa_out), .oe(pa_oe), .rdata(ra)
  );

  pio_port_latch #(.W(DW)) u_pb (
    .clk(clk), .rst(rst), .clr(mode_load), .load(wr_b), .ldata(bus_in),
    .bit_we('0), .bit_val(1'b0), .dir_in(cfg.b_in), .pin_in(pb_in),
    .q(pb_out), .oe(pb_oe), .rdata(rb)
  );

  // Port C: two independent nibbles, upper one owned by group A.
  for (genvar g = 0; g < 2; g++) begin : g_pc
    localparam int LO = g * HALF;
    pio_port_latch #(.W(HALF)) u_pc (
      .clk(clk), .rst(rst), .clr(mode_load), .load(wr_c),
      .ldata(bus_in[LO +: HALF]),
      .bit_we(bit_we[LO +: HALF]), .bit_val(bit_val),
      .dir_in((g == 0) ? cfg.cl_in : cfg.cu_in),
      .pin_in(pc_in[LO +: HALF]),
      .q(pc_out[LO +: HALF]), .oe(pc_oe[LO +: HALF]),
      .rdata(rc[LO +: HALF])
    );
  end

  always_comb begin
    bus_out = '0;
    if (rd_act) begin
      unique case (rd_sel)
        SEL_A:   bus_out = ra;
        SEL_B:   bus_out = rb;
        SEL_C:   bus_out = rc;
        default: bus_out = '0;
      endcase
    end
  end

  assign bus_oe     = rd_act;
  assign grp_a_mode = cfg.a_mode;
  assign grp_b_mode = cfg.b_mode;

  // R1: the cycle after reset shows the released, cleared state.
  assert_reset_state_R1: assert property (@(posedge clk)
    $past(rst) |-> (pa_oe == '0 && pb_oe == '0 && pc_oe == '0 &&
                    pa_out == '0 && pb_out == '0 && pc_out == '0 &&
                    grp_a_mode == 2'b00 && !grp_b_mode));

  // R9: the configuration address reads back as zero.
  assert_cfg_read_zero_R9: assert property (@(posedge clk) disable iff (rst)
    bus_oe && addr == 2'b11 |-> bus_out == '0);

endmodule

// File: tb/pio_ctrl_core_test.sv
`timescale 1ns/1ps
module pio_ctrl_core_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [1:0] addr = 2'b00;
  logic [7:0] bus_in = 8'h00, bus_out;
  logic       bus_oe;
  logic [7:0] pa_in = 8'h00, pb_in = 8'h00, pc_in = 8'h00;
  logic [7:0] pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;
  logic [1:0] grp_a_mode;
  logic       grp_b_mode;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  pio_ctrl_core uut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
    .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
    .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
    .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe),
    .grp_a_mode(grp_a_mode), .grp_b_mode(grp_b_mode)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d, input logic sel = 1'b1);
    @(negedge clk);
    addr = a; bus_in = d; cs_n = !sel; wr_n = 1'b0;
    @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b1;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v, output logic oe);
    @(negedge clk);
    addr = a; cs_n = 1'b0; rd_n = 1'b0;
    #1;
    v = bus_out; oe = bus_oe;
    cs_n = 1'b1; rd_n = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic       o;
    logic [7:0] exp_pc;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1 pa_oe", pa_oe, 8'h00);
    chk("R1 pb_oe", pb_oe, 8'h00);
    chk("R1 pc_oe", pc_oe, 8'h00);
    chk("R1 latches", {pa_out, pb_out, pc_out}, 24'h0);
    chk("R1 modes", {grp_a_mode, grp_b_mode}, 3'b000);
    chk("R1 bus_oe", bus_oe, 1'b0);
    rst = 1'b0;

    // R3/R4/R7/R8 sweep over all directions and mode codes
    for (int k = 0; k < 16; k++) begin
      for (int am = 0; am < 4; am++) begin
        for (int bm = 0; bm < 2; bm++) begin
          logic [7:0] cw, va, vb, vc, ea, eb, ec;
          logic       ai, ci_u, bi, ci_l;
          ai = k[3]; ci_u = k[2]; bi = k[1]; ci_l = k[0];
          wr(2'd0, 8'hA5); wr(2'd1, 8'h3C); wr(2'd2, 8'hC3);
          cw = {1'b1, am[1:0], ai, ci_u, bm[0], bi, ci_l};
          wr(2'd3, cw);
          chk("R4 cleared", {pa_out, pb_out, pc_out}, 24'h0);
          chk("R3 a_mode", grp_a_mode, am[1] ? 2'b10 : {1'b0, am[0]});
          chk("R3 b_mode", grp_b_mode, bm[0]);
          chk("R7 pa_oe", pa_oe, ai ? 8'h00 : 8'hFF);
          chk("R7 pb_oe", pb_oe, bi ? 8'h00 : 8'hFF);
          chk("R8 pc_oe", pc_oe, {ci_u ? 4'h0 : 4'hF, ci_l ? 4'h0 : 4'hF});
          va = 8'(k * 17 + am * 5 + 3);
          vb = ~va;
          vc = 8'(k * 29 + bm * 7 + 5);
          pa_in = va ^ 8'h5A; pb_in = vb ^ 8'h69; pc_in = vc ^ 8'h96;
          wr(2'd0, va); wr(2'd1, vb); wr(2'd2, vc);
          chk("R2 pa_out", pa_out, va);
          chk("R2 pb_out", pb_out, vb);
          chk("R2 pc_out", pc_out, vc);
          ea = ai ? pa_in : va;
          eb = bi ? pb_in : vb;
          ec = {ci_u ? pc_in[7:4] : vc[7:4], ci_l ? pc_in[3:0] : vc[3:0]};
          rd(2'd0, v, o); chk("R7 read A", {o, v}, {1'b1, ea});
          rd(2'd1, v, o); chk("R7 read B", {o, v}, {1'b1, eb});
          rd(2'd2, v, o); chk("R8 read C", {o, v}, {1'b1, ec});
        end
      end
    end

    // R8 example words
    wr(2'd3, 8'h83);
    chk("R8 83h oe", {pa_oe, pb_oe, pc_oe}, 24'hFF_00_F0);
    wr(2'd3, 8'h91);
    chk("R8 91h oe", {pa_oe, pb_oe, pc_oe}, 24'h00_FF_F0);

    // R5/R6 single-bit sweep with all outputs, group A mode 1, group B mode 1
    wr(2'd3, 8'hA4);
    exp_pc = 8'h00;
    for (int b = 0; b < 8; b++) begin
      for (int val = 0; val < 2; val++) begin
        for (int junk = 0; junk < 8; junk += 3) begin
          logic [7:0] cmd;
          cmd = {1'b0, 3'(junk), 3'(b), val[0]};
          wr(2'd3, cmd);
          exp_pc[b] = val[0];
          chk("R5 pc_out", pc_out, exp_pc);
          chk("R6 modes", {grp_a_mode, grp_b_mode}, 3'b011);
          chk("R6 oe", {pa_oe, pb_oe, pc_oe}, 24'hFF_FF_FF);
        end
      end
    end
    wr(2'd3, 8'h0E); exp_pc[7] = 1'b0;
    chk("R5 0Eh", pc_out, exp_pc);
    wr(2'd3, 8'h07); exp_pc[3] = 1'b1;
    chk("R5 07h", pc_out, exp_pc);

    // R2 deselected write ignored
    wr(2'd0, 8'h5E);
    wr(2'd0, 8'hE5, 1'b0);
    chk("R2 cs_n high", pa_out, 8'h5E);
    wr(2'd3, 8'h80, 1'b0);
    chk("R2 cs_n high cfg", pa_out, 8'h5E);

    // R9 bus drive rules
    rd(2'd3, v, o);
    chk("R9 cfg read", {o, v}, {1'b1, 8'h00});
    @(negedge clk);
    cs_n = 1'b0; rd_n = 1'b1; addr = 2'd0; #1;
    chk("R9 no rd", {bus_oe, bus_out}, 9'h000);
    cs_n = 1'b1; rd_n = 1'b0; #1;
    chk("R9 no cs", {bus_oe, bus_out}, 9'h000);
    rd_n = 1'b1;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule